// File: doc/BRIEF.md
# External Interrupt Sense and Status

This block watches eight external interrupt request pins and turns each detected event into an active-high, level-sensitive request toward a parent interrupt controller. Every pin first crosses into the block clock through a two-flop synchroniser. After that it is classified by one of four sense modes: level low, falling edge, rising edge or both edges. Software picks the mode for each pin separately.

A detected event sets a sticky status bit, and that bit drives the pin's request line. Software reads the status through a small 32-bit register bus and clears a bit by writing zero to it. Software then acknowledges the request at the parent controller. Masking and priority are handled by the parent.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the status register reads 0, every sense field reads 0 (level low), and all request outputs are low while the pins are held high.
- R2: The sense register at offset 0x14 holds a 2-bit mode for pin n at bits [2n+1:2n]. It reads back exactly what was written, and bits [31:16] read as zero.
- R3: Sense code 0 (level low) sets status bit n on every cycle in which the synchronised pin is low. This includes the cycle right after a clear.
- R4: Sense code 1 (falling edge) sets status bit n on a high-to-low change of the pin. A low-to-high change does not set it.
- R5: Sense code 2 (rising edge) sets status bit n on a low-to-high change of the pin. A high-to-low change does not set it.
- R6: Sense code 3 (both edges) sets status bit n on any change of the pin.
- R7: The status register sits at offset 0x10, with bit n for pin n. Writing 0 to a bit clears it. Writing 1 to a bit leaves it unchanged. A bit never falls without such a write.
- R8: When an event and a clear-by-zero for the same bit fall in the same cycle, the bit stays set.
- R9: Request output n is high exactly when status bit n is set.
- R10: Reads from any offset other than 0x10 and 0x14 return zero. Writes to such offsets change no register.
- R11: A pin change that is driven between clock edges shows up on the status and the request on the third rising edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_pin | input | 8 | External interrupt request pins, asynchronous |
| irq_req | output | 8 | Level-high requests toward the parent controller |

## Verification
Two things can land on a status bit in the same clock edge: a fresh event from the detector and a software write that clears the bit. The bench provokes this in two ways. First, it holds a pin low in level-low mode and writes zero to its status bit. Second, it times a falling-edge clear write so that it commits on the very edge where the synchronised falling edge is detected. In both cases the bit must read back set and its request must stay high. A neighbouring bit cleared by the same write must read back zero.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LVL_LOW = 2'd0,
    SENSE_FALL    = 2'd1,
    SENSE_RISE    = 2'd2,
    SENSE_BOTH    = 2'd3
  } sense_mode_e;

  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_SENSE  = 8'h14;

endpackage

// File: rtl/eis_pin_sync.sv
module eis_pin_sync #(
  parameter int unsigned NP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] pin_async,
  output logic [NP-1:0] pin_sync
);

  logic [NP-1:0] meta_q;
  logic [NP-1:0] stable_q;

  // Reset to the idle-high level so that idle pins produce no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '1;
      stable_q <= '1;
    end else begin
      meta_q   <= pin_async;
      stable_q <= meta_q;
    end
  end

  assign pin_sync = stable_q;

endmodule

// File: rtl/eis_sense_detect.sv
module eis_sense_detect
  import ext_irq_pkg::*;
#(
  parameter int unsigned NP = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NP-1:0]   pin_sync,
  input  logic [2*NP-1:0] sense_cfg,
  output logic [NP-1:0]   event_hit
);

  logic [NP-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= pin_sync;
  end

  for (genvar n = 0; n < NP; n++) begin : g_pin
    sense_mode_e mode;
    assign mode = sense_mode_e'(sense_cfg[2*n +: 2]);

    always_comb begin
      unique case (mode)
        SENSE_LVL_LOW: event_hit[n] = ~pin_sync[n];
        SENSE_FALL:    event_hit[n] = prev_q[n] & ~pin_sync[n];
        SENSE_RISE:    event_hit[n] = ~prev_q[n] & pin_sync[n];
        default:       event_hit[n] = prev_q[n] ^ pin_sync[n];
      endcase
    end
  end

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int unsigned NP = 8,
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NP-1:0] irq_pin,
  output logic [NP-1:0] irq_req
);

  localparam int unsigned SW = 2 * NP;

  logic [NP-1:0] pin_sync;
  logic [NP-1:0] event_hit;
  logic [NP-1:0] status_q, status_d;
  logic [SW-1:0] sense_q, sense_d;
  logic          sel_status, sel_sense;
  logic          status_en, sense_en;
  logic          unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DW-1:SW];

  eis_pin_sync #(.NP(NP)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_async(irq_pin),
    .pin_sync (pin_sync)
  );

  eis_sense_detect #(.NP(NP)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_sync (pin_sync),
    .sense_cfg(sense_q),
    .event_hit(event_hit)
  );

  assign sel_status = (bus_addr == AW'(OFS_STATUS));
  assign sel_sense  = (bus_addr == AW'(OFS_SENSE));

  // Next state: a written zero clears the bit, and a same-cycle event re-sets it.
  always_comb begin
    status_en = (bus_we && sel_status) || (|event_hit);
    status_d  = status_q;
    if (bus_we && sel_status) status_d = status_q & bus_wdata[NP-1:0];
    status_d  = status_d | event_hit;
  end

  always_comb begin
    sense_en = bus_we && sel_sense;
    sense_d  = bus_wdata[SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sense_q <= '0;
    else if (sense_en) sense_q <= sense_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_status)     bus_rdata[NP-1:0] = status_q;
    else if (sel_sense) bus_rdata[SW-1:0] = sense_q;
  end

  assign irq_req = status_q;

endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk
  import ext_irq_pkg::*;
#(
  parameter int unsigned NP = 8,
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic [NP-1:0] irq_req,
  input logic [2*NP-1:0] sense_q
);

  logic wr_status;
  assign wr_status = bus_we && (bus_addr == AW'(OFS_STATUS));

  assert_sense_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(OFS_SENSE)) |-> (bus_rdata[DW-1:2*NP] == '0));

  assert_sense_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(OFS_SENSE)) |=> (sense_q == $past(bus_wdata[2*NP-1:0])));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != AW'(OFS_STATUS) && bus_addr != AW'(OFS_SENSE)) |-> (bus_rdata == '0));

  assert_clear_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(irq_req) & ~irq_req)) |-> $past(wr_status));

  assert_one_keeps_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status |=> ((($past(irq_req) & $past(bus_wdata[NP-1:0])) & ~irq_req) == '0));

  assert_req_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(OFS_STATUS)) |-> (bus_rdata[NP-1:0] == irq_req));

endmodule

bind ext_irq_sense ext_irq_sense_chk #(.NP(NP), .AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq_req  (irq_req),
  .sense_q  (sense_q)
);

// File: tb/ext_irq_sense_bench.sv
module ext_irq_sense_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_pin;
  logic [7:0]  irq_req;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  ext_irq_sense u_ext_irq_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_pin  (irq_pin),
    .irq_req  (irq_req)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0; bus_addr = 8'h00;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 8'h00;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Pins high, set mode, let pipeline settle, then clear status.
  task automatic prep(logic [15:0] sense);
    @(negedge clk); irq_pin = 8'hFF;
    idle(4);
    wr(8'h14, {16'h0, sense});
    idle(2);
    wr(8'h10, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h10, d); chk("R1 status", d, 0);
    rd(8'h14, d); chk("R1 sense", d, 0);
    chk("R1 req", {24'h0, irq_req}, 0);
  endtask

  task automatic t_sense_reg;
    logic [31:0] d;
    wr(8'h14, 32'hFFFF_A5C3);
    rd(8'h14, d); chk("R2 readback", d, 32'h0000_A5C3);
    wr(8'h14, 32'h0000_1E78);
    rd(8'h14, d); chk("R2 readback2", d, 32'h0000_1E78);
  endtask

  task automatic t_level_low;
    logic [31:0] d;
    prep(16'h0000);
    @(negedge clk); irq_pin[2] = 1'b0;
    idle(2);
    chk("R11 not yet", {24'h0, irq_req}, 0);
    idle(1);
    chk("R3 level set", {24'h0, irq_req}, 32'h04);
    chk("R9 req", {24'h0, irq_req}, 32'h04);
    wr(8'h10, 32'h0);
    rd(8'h10, d); chk("R3 reassert after clear", d, 32'h04);
    chk("R8 level vs clear", {24'h0, irq_req}, 32'h04);
    @(negedge clk); irq_pin[2] = 1'b1;
    idle(4);
    wr(8'h10, 32'h0);
    rd(8'h10, d); chk("R3 clear after release", d, 0);
  endtask

  task automatic t_falling;
    logic [31:0] d;
    prep(16'h5555);
    @(negedge clk); irq_pin[5] = 1'b0;
    idle(3);
    rd(8'h10, d); chk("R4 falling", d, 32'h20);
    wr(8'h10, 32'h0);
    idle(3);
    rd(8'h10, d); chk("R4 low hold no event", d, 0);
    @(negedge clk); irq_pin[5] = 1'b1;
    idle(4);
    rd(8'h10, d); chk("R4 rise ignored", d, 0);
  endtask

  task automatic t_rising;
    logic [31:0] d;
    prep(16'hAAAA);
    @(negedge clk); irq_pin[0] = 1'b0;
    idle(4);
    rd(8'h10, d); chk("R5 fall ignored", d, 0);
    @(negedge clk); irq_pin[0] = 1'b1;
    idle(2);
    chk("R11 rise not yet", {24'h0, irq_req}, 0);
    idle(1);
    rd(8'h10, d); chk("R5 rising", d, 32'h01);
  endtask

  task automatic t_both;
    logic [31:0] d;
    prep(16'hFFFF);
    @(negedge clk); irq_pin[7] = 1'b0;
    idle(3);
    rd(8'h10, d); chk("R6 fall edge", d, 32'h80);
    wr(8'h10, 32'h0);
    rd(8'h10, d); chk("R6 cleared", d, 0);
    @(negedge clk); irq_pin[7] = 1'b1;
    idle(3);
    rd(8'h10, d); chk("R6 rise edge", d, 32'h80);
  endtask

  task automatic t_clear_keep;
    logic [31:0] d;
    prep(16'h5555);
    @(negedge clk); irq_pin[1] = 1'b0; irq_pin[6] = 1'b0;
    idle(4);
    rd(8'h10, d); chk("R7 two set", d, 32'h42);
    wr(8'h10, 32'hFFFF_FFBF);
    rd(8'h10, d); chk("R7 zero clears one keeps", d, 32'h02);
    chk("R9 req follows", {24'h0, irq_req}, 32'h02);
  endtask

  task automatic t_event_vs_clear;
    logic [31:0] d;
    prep(16'h5555);
    wr(8'h10, 32'h0);
    @(negedge clk); irq_pin[3] = 1'b0; irq_pin[4] = 1'b0;
    idle(3);
    wr(8'h10, 32'h0);
    rd(8'h10, d); chk("R7 clear after event", d, 0);
    @(negedge clk); irq_pin = 8'hFF;
    idle(4);
    @(negedge clk); irq_pin[3] = 1'b0;
    idle(1);
    // Write lands on the third edge after the pin change, with the event.
    @(negedge clk); bus_addr = 8'h10; bus_we = 1'b1; bus_wdata = 32'h0;
    @(negedge clk); bus_we = 1'b0; bus_addr = 8'h00;
    rd(8'h10, d); chk("R8 event beats clear", d, 32'h08);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    prep(16'h0000);
    wr(8'h14, 32'h0000_9999);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0);
    wr(8'h11, 32'h0);
    rd(8'h14, d); chk("R10 sense untouched", d, 32'h0000_9999);
    @(negedge clk); irq_pin[1] = 1'b0;
    idle(4);
    @(negedge clk); irq_pin[1] = 1'b1;
    idle(3);
    wr(8'h1C, 32'h0);
    rd(8'h10, d); chk("R10 status untouched", d, 32'h02);
    rd(8'h04, d); chk("R10 read zero", d, 0);
    rd(8'h15, d); chk("R10 read zero odd", d, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; irq_pin = 8'hFF;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_sense_reg;
    t_level_low;
    t_falling;
    t_rising;
    t_both;
    t_clear_keep;
    t_event_vs_clear;
    t_unmapped;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog got=hang exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule